// File: doc/BRIEF.md
# Spike-timing weight update unit

This block holds the weight of one synapse and adjusts it from the relative timing of the spikes on its two sides. For each side it keeps the timestep of the most recent spike, taken from a global timestep counter. When a spike arrives on one side, the unit measures how long ago the other side last fired. If an input spike came before an output spike, the weight goes up. If an input spike came after an output spike, the weight goes down. The size of the step halves every 2^tau timesteps of separation. An input spike and an output spike in the same timestep count as an increase with zero separation.

Software sets the two step amplitudes, the decay shift and a maximum pairing window. Outside that window a spike pair changes nothing. A write port loads the weight directly, and the stored weight is always visible on an output. The weight is a signed value that clamps at its limits instead of wrapping.

Top module: `stdp_syn_update`

## Requirements
- R1: After reset the weight output reads 0 and neither side has spike history, so the first spike after reset leaves the weight unchanged.
- R2: An output spike (post_spike_i) at timestep t, when the last input spike was at p, adds amp_pot_i >> ((t-p) >> tau_i) to the weight. The weight output shows the result after the same clock edge.
- R3: An input spike (pre_spike_i) at timestep t, when the last output spike was at q, subtracts amp_dep_i >> ((t-q) >> tau_i) from the weight.
- R4: When pre_spike_i and post_spike_i are both high in the same cycle, the weight rises by the full amp_pot_i, and no decrease is applied.
- R5: A pairing whose separation is greater than win_max_i changes nothing. A separation equal to win_max_i is still applied. A cycle with no spike and no write holds the weight.
- R6: When (separation >> tau_i) is 8 or more, the step is zero.
- R7: The weight saturates at +127 and -128 and never wraps.
- R8: With wt_we_i high, wt_wdata_i is loaded on that edge. A spike update in the same cycle is discarded.
- R9: Pairing always uses the most recent spike on the opposite side. That spike can be paired again by later spikes.
- R10: Separation is computed modulo 2^TS_W, so pairs that straddle a wrap of the timestep counter still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tstep_i | input | TS_W | Global timestep counter |
| pre_spike_i | input | 1 | Input-side spike strobe |
| post_spike_i | input | 1 | Output-side spike strobe |
| amp_pot_i | input | AMP_W | Increase amplitude (unsigned) |
| amp_dep_i | input | AMP_W | Decrease amplitude magnitude (unsigned) |
| tau_i | input | TAU_W | log2 of the decay window constant |
| win_max_i | input | TS_W | Largest separation that still updates |
| wt_we_i | input | 1 | Weight write enable |
| wt_wdata_i | input | W_W | Weight write data (signed) |
| wt_o | output | W_W | Current weight (signed) |

## Verification
Four kinds of spike pattern are driven: input-before-output, output-before-input, a coincident pair, and an output spike that pairs again with an old input spike. Comparing them separates the sign rule from the same-step rule and from nearest-spike pairing. Separations are chosen to land just inside and just outside the window, and to reach a shift of 7 and of 8. Those cases split the window cut-off from the exponent cut-off. Further runs cover amplitudes that drive the weight into either rail, a write that collides with an update, and a pair that crosses the counter wrap.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_POT  = 2'd1,
    EV_DEP  = 2'd2,
    EV_LOAD = 2'd3
  } stdp_ev_e;
endpackage

// File: rtl/stdp_spike_track.sv
module stdp_spike_track #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            spike_i,
  input  logic [TS_W-1:0] tstep_i,
  input  logic [TS_W-1:0] win_max_i,
  output logic [TS_W-1:0] diff_o,
  output logic            in_win_o
);
  logic [TS_W-1:0] last_ts_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ts_q <= '0;
      seen_q    <= 1'b0;
    end else if (spike_i) begin
      last_ts_q <= tstep_i;
      seen_q    <= 1'b1;
    end
  end

  // modular distance to the last recorded spike
  assign diff_o   = tstep_i - last_ts_q;
  assign in_win_o = seen_q && (diff_o <= win_max_i);

  assert_history_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_i |=> (seen_q && last_ts_q == $past(tstep_i)));
endmodule

// File: rtl/stdp_decay.sv
module stdp_decay #(
  parameter int AMP_W = 8,
  parameter int TS_W  = 16,
  parameter int TAU_W = 4
) (
  input  logic [AMP_W-1:0] amp_i,
  input  logic [TS_W-1:0]  diff_i,
  input  logic [TAU_W-1:0] tau_i,
  output logic [AMP_W-1:0] mag_o
);
  logic [TS_W-1:0] shamt;

  assign shamt = diff_i >> tau_i;
  // base-2 decay; shifts of AMP_W or more give zero
  assign mag_o = (shamt >= TS_W'(AMP_W)) ? '0 : (amp_i >> shamt);
endmodule

// File: rtl/stdp_sat_add.sv
module stdp_sat_add #(
  parameter int W_W   = 8,
  parameter int AMP_W = 8
) (
  input  logic [W_W-1:0]   w_i,
  input  logic [AMP_W-1:0] mag_i,
  input  logic             sub_i,
  output logic [W_W-1:0]   w_o
);
  localparam int SUM_W = ((W_W > AMP_W) ? W_W : AMP_W) + 2;
  localparam logic signed [SUM_W-1:0] W_MAX = SUM_W'((1 << (W_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] W_MIN = -SUM_W'(1 << (W_W - 1));

  logic signed [SUM_W-1:0] w_ext, m_ext, sum;

  assign w_ext = SUM_W'($signed(w_i));
  assign m_ext = SUM_W'(mag_i);
  assign sum   = sub_i ? (w_ext - m_ext) : (w_ext + m_ext);

  always_comb begin
    if (sum > W_MAX)      w_o = W_MAX[W_W-1:0];
    else if (sum < W_MIN) w_o = W_MIN[W_W-1:0];
    else                  w_o = sum[W_W-1:0];
  end
endmodule

// File: rtl/stdp_syn_update.sv
module stdp_syn_update
  import stdp_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int W_W   = 8,
  parameter int AMP_W = 8,
  parameter int TAU_W = $clog2(TS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  tstep_i,
  input  logic             pre_spike_i,
  input  logic             post_spike_i,
  input  logic [AMP_W-1:0] amp_pot_i,
  input  logic [AMP_W-1:0] amp_dep_i,
  input  logic [TAU_W-1:0] tau_i,
  input  logic [TS_W-1:0]  win_max_i,
  input  logic             wt_we_i,
  input  logic [W_W-1:0]   wt_wdata_i,
  output logic [W_W-1:0]   wt_o
);
  logic [TS_W-1:0]  pre_diff, post_diff, dec_diff;
  logic             pre_in_win, post_in_win;
  logic [AMP_W-1:0] dec_amp, dec_mag;
  logic [W_W-1:0]   wt_q, wt_next_upd;
  stdp_ev_e         ev;

  stdp_spike_track #(.TS_W(TS_W)) u_pre_trk (
    .clk_i, .rst_ni, .spike_i(pre_spike_i), .tstep_i, .win_max_i,
    .diff_o(pre_diff), .in_win_o(pre_in_win));

  stdp_spike_track #(.TS_W(TS_W)) u_post_trk (
    .clk_i, .rst_ni, .spike_i(post_spike_i), .tstep_i, .win_max_i,
    .diff_o(post_diff), .in_win_o(post_in_win));

  // write wins; coincident spikes resolve to potentiation at zero gap
  always_comb begin
    if (wt_we_i)                                        ev = EV_LOAD;
    else if (post_spike_i && (pre_spike_i || pre_in_win)) ev = EV_POT;
    else if (pre_spike_i && post_in_win)                ev = EV_DEP;
    else                                                ev = EV_NONE;
  end

  assign dec_amp  = (ev == EV_DEP) ? amp_dep_i : amp_pot_i;
  assign dec_diff = (ev == EV_DEP) ? post_diff : (pre_spike_i ? '0 : pre_diff);

  stdp_decay #(.AMP_W(AMP_W), .TS_W(TS_W), .TAU_W(TAU_W)) u_decay (
    .amp_i(dec_amp), .diff_i(dec_diff), .tau_i, .mag_o(dec_mag));

  stdp_sat_add #(.W_W(W_W), .AMP_W(AMP_W)) u_sat (
    .w_i(wt_q), .mag_i(dec_mag), .sub_i(ev == EV_DEP), .w_o(wt_next_upd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wt_q <= '0;
    else begin
      case (ev)
        EV_LOAD:        wt_q <= wt_wdata_i;
        EV_POT, EV_DEP: wt_q <= wt_next_upd;
        default:        wt_q <= wt_q;
      endcase
    end
  end

  assign wt_o = wt_q;

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_we_i |=> (wt_o == $past(wt_wdata_i)));
  assert_pot_no_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wt_we_i && post_spike_i) |=> ($signed(wt_o) >= $signed($past(wt_o))));
  assert_same_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wt_we_i && pre_spike_i && post_spike_i) |=> ($signed(wt_o) >= $signed($past(wt_o))));
  assert_dep_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wt_we_i && pre_spike_i && !post_spike_i) |=> ($signed(wt_o) <= $signed($past(wt_o))));
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wt_we_i && !pre_spike_i && !post_spike_i) |=> $stable(wt_o));
  assert_mag_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_mag <= dec_amp);
endmodule

// File: tb/stdp_syn_update_tb_top.sv
module stdp_syn_update_tb_top;
  localparam int TS_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [TS_W-1:0] tstep = '0;
  logic pre = 1'b0, post = 1'b0;
  logic [7:0] amp_pot = 8'd64, amp_dep = 8'd48;
  logic [3:0] tau = 4'd2;
  logic [TS_W-1:0] win_max = 16'd40;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] wt;

  int checks = 0, fails = 0;
  int base = 100;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stdp_syn_update dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tstep_i(tstep), .pre_spike_i(pre),
    .post_spike_i(post), .amp_pot_i(amp_pot), .amp_dep_i(amp_dep),
    .tau_i(tau), .win_max_i(win_max), .wt_we_i(we), .wt_wdata_i(wdata),
    .wt_o(wt));

  task automatic check(string req, int exp);
    int act;
    act = int'($signed(wt));
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s weight act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, result visible at the next negedge
  task automatic cyc(bit p, bit q, int ts, bit w = 0, int wd = 0);
    @(negedge clk);
    pre = p; post = q; tstep = TS_W'(ts); we = w; wdata = 8'(wd);
    @(negedge clk);
    pre = 0; post = 0; we = 0;
  endtask

  task automatic load(int v);
    cyc(0, 0, base, 1, v);
  endtask

  task automatic t_reset;
    check("R1", 0);
    cyc(1, 0, 3);
    check("R1", 0);
  endtask

  task automatic t_pot;
    base += 1000; load(0);
    cyc(1, 0, base);
    cyc(0, 1, base + 5);
    check("R2", 32);
    cyc(0, 1, base + 9);
    check("R9", 48);
  endtask

  task automatic t_dep;
    base += 1000; load(10);
    cyc(0, 1, base);
    cyc(1, 0, base + 3);
    check("R3", -38);
  endtask

  task automatic t_same;
    base += 1000; load(0);
    cyc(1, 1, base);
    check("R4", 64);
  endtask

  task automatic t_window;
    base += 1000; tau = 3; load(0);
    cyc(1, 0, base);
    cyc(0, 1, base + 41);
    check("R5", 0);
    cyc(1, 0, base + 100);
    cyc(0, 1, base + 140);
    check("R5", 2);
    tau = 2;
  endtask

  task automatic t_shift;
    base += 1000; tau = 0; amp_pot = 8'd255; load(5);
    cyc(1, 0, base);
    cyc(0, 1, base + 7);
    check("R6", 6);
    cyc(0, 1, base + 8);
    check("R6", 6);
    tau = 2; amp_pot = 8'd64;
  endtask

  task automatic t_sat;
    base += 1000; amp_pot = 8'd255; amp_dep = 8'd255; load(120);
    cyc(1, 1, base);
    check("R7", 127);
    base += 1000; load(-120);
    cyc(0, 1, base);
    cyc(1, 0, base + 1);
    check("R7", -128);
    amp_pot = 8'd64; amp_dep = 8'd48;
  endtask

  task automatic t_write;
    base += 1000; load(0);
    cyc(1, 1, base, 1, 7);
    check("R8", 7);
    cyc(0, 0, base + 1);
    check("R8", 7);
  endtask

  task automatic t_wrap;
    load(0);
    cyc(1, 0, 65534);
    cyc(0, 1, 2);
    check("R10", 32);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pot();
    t_dep();
    t_same();
    t_window();
    t_shift();
    t_sat();
    t_write();
    t_wrap();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule